// File: doc/BRIEF.md
# Burst-Mode Gate Pulse Generator

This block drives the gate of the primary-side power switch in a flyback converter that runs in burst mode. While a burst is active it produces a train of gate pulses, each made of a high time followed by a low time. When the synchronized upper-threshold flag reports that the output has charged far enough, the pulse in progress is allowed to finish and switching stops. The converter output then discharges into the load, and a separate slope measurement runs during that time. A new burst starts when the synchronized lower-threshold flag reports that the output has sagged below its floor.

The high and low times come from a 16-entry table that logic outside the block can program. Each time the measurement logic latches a new 10-bit discharge count, it pulses a valid strobe. The block then looks up the entry addressed by the four most significant bits of that count. The selected pair is staged and only takes effect at the start of the next pulse period, so a pulse is never cut short or stretched. After reset, a default pair is in force until the first measurement selects a table entry.

Top module: `burst_gate_gen`

## Requirements
- R1: While `rstN` is low, `gate` is low. Reset leaves the block in burst-off, with the active and staged pair both set to the defaults DEF_HIGH=3 and DEF_LOW=5 clock cycles.
- R2: In burst-off, a cycle that samples `belowLo`=1 and `aboveHi`=0 starts a burst, and `gate` is high from the next cycle onward.
- R3: During a burst, every period drives `gate` high for exactly H cycles and then low for exactly L cycles, where (H, L) is the active pair. Periods repeat back to back.
- R4: The table has 16 entries and is written through `tblWrEn`, `tblWrAddr` (4 bits), `tblWrHigh` and `tblWrLow`. Reset loads every entry with the default pair.
- R5: A cycle with `measValid`=1 stages the entry at index `measCount[9:6]`. Bits 5:0 of `measCount` do not affect the selection.
- R6: A staged pair becomes active only at the first cycle of the next period, including the first period of a new burst. The period in progress keeps its pair.
- R7: Writing the table, with no `measValid` strobe, does not change the waveform.
- R8: A written high or low time of 0 is stored as 1.
- R9: When `aboveHi`=1 is sampled during a burst, the period in progress completes both its high and low parts. After that the block enters burst-off, and `gate` stays low until the R2 condition is met.
- R10: In burst-off, `aboveHi`=1 prevents a restart even when `belowLo`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| aboveHi | input | 1 | Synchronized flag: output at or above the upper threshold |
| belowLo | input | 1 | Synchronized flag: output below the lower threshold |
| measCount | input | 10 | Latched discharge-slope count |
| measValid | input | 1 | One-cycle strobe: `measCount` has just been updated |
| tblWrEn | input | 1 | Table write enable |
| tblWrAddr | input | 4 | Table entry to write |
| tblWrHigh | input | 8 | High time in cycles to store |
| tblWrLow | input | 8 | Low time in cycles to store |
| gate | output | 1 | Power switch gate drive |

## Verification
The pulse train is measured as run lengths of `gate` under four kinds of parameter source: the reset defaults, a freshly selected table entry, an entry written with zeros, and the table after a second reset. These runs separate a correct pair from one that is swapped, off by one, or never clamped. A selection strobe issued in the first cycle of a period shows whether the new pair is applied early, which would change the current period, or only at the boundary. The threshold flags are exercised in three situations: the upper flag raised in the first cycle of a period, both flags raised together while idle, and a reset asserted during a high pulse. These cover pulse completion, the priority of the upper flag, and the forced-low gate.

// File: rtl/burst_gate_pkg.sv
`timescale 1ns/1ps
package burst_gate_pkg;

  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic startPeriod;  // load staged pair, begin high time
    logic enterLow;     // begin low time of active pair
  } ctl_strobe_t;

endpackage

// File: rtl/burst_gate_table.sv
`timescale 1ns/1ps
module burst_gate_table #(
  parameter int IDX_W    = 4,
  parameter int CNT_W    = 8,
  parameter int DEF_HIGH = 3,
  parameter int DEF_LOW  = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrAddr,
  input  logic [CNT_W-1:0] wrHigh,
  input  logic [CNT_W-1:0] wrLow,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [CNT_W-1:0] rdHigh,
  output logic [CNT_W-1:0] rdLow
);

  localparam int DEPTH = 1 << IDX_W;

  logic [CNT_W-1:0] highMem [DEPTH];
  logic [CNT_W-1:0] lowMem  [DEPTH];
  logic [CNT_W-1:0] wrHighClamped;
  logic [CNT_W-1:0] wrLowClamped;

  // a zero duration is stored as one cycle
  assign wrHighClamped = (wrHigh == '0) ? CNT_W'(1) : wrHigh;
  assign wrLowClamped  = (wrLow  == '0) ? CNT_W'(1) : wrLow;

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        highMem[e] <= CNT_W'(DEF_HIGH);
        lowMem[e]  <= CNT_W'(DEF_LOW);
      end else if (wrEn && (wrAddr == IDX_W'(e))) begin
        highMem[e] <= wrHighClamped;
        lowMem[e]  <= wrLowClamped;
      end
    end
  end

  assign rdHigh = highMem[rdIdx];
  assign rdLow  = lowMem[rdIdx];

endmodule

// File: rtl/burst_gate_ctrl.sv
`timescale 1ns/1ps
module burst_gate_ctrl
  import burst_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        aboveHi,
  input  logic        belowLo,
  input  logic        cntZero,
  output ctl_strobe_t strobes,
  output logic        offState,
  output logic        gateOut
);

  phase_e state, stateNext;
  logic   stopReq;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      PH_OFF: begin
        if (belowLo && !aboveHi) begin
          stateNext           = PH_HIGH;
          strobes.startPeriod = 1'b1;
        end
      end
      PH_HIGH: begin
        if (cntZero) begin
          stateNext        = PH_LOW;
          strobes.enterLow = 1'b1;
        end
      end
      PH_LOW: begin
        if (cntZero) begin
          if (stopReq || aboveHi) begin
            stateNext = PH_OFF;
          end else begin
            stateNext           = PH_HIGH;
            strobes.startPeriod = 1'b1;
          end
        end
      end
      default: stateNext = PH_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= PH_OFF;
      stopReq <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == PH_OFF)
        stopReq <= 1'b0;
      else if (aboveHi)
        stopReq <= 1'b1;
    end
  end

  assign offState = (state == PH_OFF);
  assign gateOut  = (state == PH_HIGH);

endmodule

// File: rtl/burst_gate_dp.sv
`timescale 1ns/1ps
module burst_gate_dp
  import burst_gate_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int DEF_HIGH = 3,
  parameter int DEF_LOW  = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctl_strobe_t      strobes,
  input  logic             measValid,
  input  logic [CNT_W-1:0] selHigh,
  input  logic [CNT_W-1:0] selLow,
  output logic             cntZero,
  output logic [CNT_W-1:0] curHigh,
  output logic [CNT_W-1:0] curLow
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] stagedHigh;
  logic [CNT_W-1:0] stagedLow;
  logic [CNT_W-1:0] cnt;

  // staged pair: follows the latest measurement
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stagedHigh <= CNT_W'(DEF_HIGH);
      stagedLow  <= CNT_W'(DEF_LOW);
    end else if (measValid) begin
      stagedHigh <= selHigh;
      stagedLow  <= selLow;
    end
  end

  // active pair: changes only at a period boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curHigh <= CNT_W'(DEF_HIGH);
      curLow  <= CNT_W'(DEF_LOW);
    end else if (strobes.startPeriod) begin
      curHigh <= stagedHigh;
      curLow  <= stagedLow;
    end
  end

  // down counter over the remaining cycles of the current half-period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cnt <= '0;
    else if (strobes.startPeriod)
      cnt <= stagedHigh - ONE;
    else if (strobes.enterLow)
      cnt <= curLow - ONE;
    else if (cnt != '0)
      cnt <= cnt - ONE;
  end

  assign cntZero = (cnt == '0);

endmodule

// File: rtl/burst_gate_gen.sv
`timescale 1ns/1ps
module burst_gate_gen
  import burst_gate_pkg::*;
#(
  parameter int MEAS_W   = 10,
  parameter int IDX_W    = 4,
  parameter int CNT_W    = 8,
  parameter int DEF_HIGH = 3,
  parameter int DEF_LOW  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aboveHi,
  input  logic              belowLo,
  input  logic [MEAS_W-1:0] measCount,
  input  logic              measValid,
  input  logic              tblWrEn,
  input  logic [IDX_W-1:0]  tblWrAddr,
  input  logic [CNT_W-1:0]  tblWrHigh,
  input  logic [CNT_W-1:0]  tblWrLow,
  output logic              gate
);

  ctl_strobe_t      strobes;
  logic             cntZero;
  logic             offState;
  logic [CNT_W-1:0] selHigh;
  logic [CNT_W-1:0] selLow;
  logic [CNT_W-1:0] curHigh;
  logic [CNT_W-1:0] curLow;

  burst_gate_table #(
    .IDX_W(IDX_W), .CNT_W(CNT_W), .DEF_HIGH(DEF_HIGH), .DEF_LOW(DEF_LOW)
  ) u_table (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (tblWrEn),
    .wrAddr (tblWrAddr),
    .wrHigh (tblWrHigh),
    .wrLow  (tblWrLow),
    .rdIdx  (measCount[MEAS_W-1 -: IDX_W]),
    .rdHigh (selHigh),
    .rdLow  (selLow)
  );

  burst_gate_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .aboveHi  (aboveHi),
    .belowLo  (belowLo),
    .cntZero  (cntZero),
    .strobes  (strobes),
    .offState (offState),
    .gateOut  (gate)
  );

  burst_gate_dp #(
    .CNT_W(CNT_W), .DEF_HIGH(DEF_HIGH), .DEF_LOW(DEF_LOW)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .measValid (measValid),
    .selHigh   (selHigh),
    .selLow    (selLow),
    .cntZero   (cntZero),
    .curHigh   (curHigh),
    .curLow    (curLow)
  );

endmodule

// File: rtl/burst_gate_chk.sv
`timescale 1ns/1ps
module burst_gate_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             gate,
  input logic             aboveHi,
  input logic             belowLo,
  input logic             offState,
  input logic             measValid,
  input logic [CNT_W-1:0] selHigh,
  input logic [CNT_W-1:0] selLow,
  input logic [CNT_W-1:0] curHigh
);

  // R1
  reset_gate_low_chk: assert property (@(posedge clk) !rstN |-> !gate);

  // R2
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    offState && belowLo && !aboveHi |=> gate);

  // R9
  stay_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    offState && !belowLo |=> !gate);

  // R10
  restart_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    offState && aboveHi |=> !gate);

  // R6
  param_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curHigh) |-> $rose(gate));

  // R8
  sel_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    measValid |-> (selHigh != '0) && (selLow != '0));

endmodule

bind burst_gate_gen burst_gate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .gate      (gate),
  .aboveHi   (aboveHi),
  .belowLo   (belowLo),
  .offState  (offState),
  .measValid (measValid),
  .selHigh   (selHigh),
  .selLow    (selLow),
  .curHigh   (curHigh)
);

// File: tb/burst_gate_gen_bench.sv
`timescale 1ns/1ps
module burst_gate_gen_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic       aboveHi;
  logic       belowLo;
  logic [9:0] measCount;
  logic       measValid;
  logic       tblWrEn;
  logic [3:0] tblWrAddr;
  logic [7:0] tblWrHigh;
  logic [7:0] tblWrLow;
  logic       gate;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  burst_gate_gen u_burst_gate_gen (
    .clk(clk), .rstN(rstN), .aboveHi(aboveHi), .belowLo(belowLo),
    .measCount(measCount), .measValid(measValid), .tblWrEn(tblWrEn),
    .tblWrAddr(tblWrAddr), .tblWrHigh(tblWrHigh), .tblWrLow(tblWrLow),
    .gate(gate)
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // count consecutive negedge samples of gate equal to v
  task automatic run_len(input logic v, input int limit, output int n);
    n = 0;
    while (gate === v && n < limit) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic tbl_write(input logic [3:0] a, input logic [7:0] h, input logic [7:0] l);
    tblWrEn = 1'b1; tblWrAddr = a; tblWrHigh = h; tblWrLow = l;
    @(negedge clk);
    tblWrEn = 1'b0;
  endtask

  task automatic pulse_meas(input logic [3:0] idx, input logic [5:0] lowBits);
    measCount = {idx, lowBits};
    measValid = 1'b1;
    fork begin @(negedge clk); measValid = 1'b0; end join_none
  endtask

  task automatic pulse_above();
    aboveHi = 1'b1;
    fork begin @(negedge clk); aboveHi = 1'b0; end join_none
  endtask

  task automatic start_burst();
    belowLo = 1'b1;
    @(negedge clk);
    belowLo = 1'b0;
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check(int'(gate), 0, "R1 gate during reset");
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(int'(gate), 0, "R1 idle in burst-off after reset");
  endtask

  task automatic test_default_and_write_only();
    int h, l;
    tbl_write(4'd5, 8'd2, 8'd4);
    tbl_write(4'd7, 8'd0, 8'd0);
    start_burst();
    check(int'(gate), 1, "R2 gate high after restart");
    run_len(1'b1, 100, h); check(h, 3, "R7 high after table write only");
    run_len(1'b0, 100, l); check(l, 5, "R3 default low time");
  endtask

  task automatic test_select();
    int h, l;
    pulse_meas(4'd5, 6'd37);
    run_len(1'b1, 100, h); check(h, 3, "R6 current period high kept");
    run_len(1'b0, 100, l); check(l, 5, "R6 current period low kept");
    run_len(1'b1, 100, h); check(h, 2, "R5 selected high time");
    run_len(1'b0, 100, l); check(l, 4, "R4 selected low time");
  endtask

  task automatic test_clamp();
    int h, l;
    pulse_meas(4'd7, 6'd0);
    run_len(1'b1, 100, h); check(h, 2, "R6 boundary before clamp pair");
    run_len(1'b0, 100, l); check(l, 4, "R6 boundary before clamp pair low");
    run_len(1'b1, 100, h); check(h, 1, "R8 zero high stored as 1");
    run_len(1'b0, 100, l); check(l, 1, "R8 zero low stored as 1");
  endtask

  task automatic test_stop();
    int h, l;
    pulse_meas(4'd5, 6'd0);
    run_len(1'b1, 100, h); check(h, 1, "R3 1/1 period high");
    run_len(1'b0, 100, l); check(l, 1, "R3 1/1 period low");
    pulse_above();
    run_len(1'b1, 100, h); check(h, 2, "R9 pulse completes after stop");
    run_len(1'b0, 40, l);  check(l, 40, "R9 switching stopped");
  endtask

  task automatic test_block();
    int h;
    belowLo = 1'b1; aboveHi = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(int'(gate), 0, "R10 upper flag blocks restart");
    end
    aboveHi = 1'b0;
    @(negedge clk);
    belowLo = 1'b0;
    check(int'(gate), 1, "R2 restart once upper flag clears");
    run_len(1'b1, 100, h); check(h, 2, "R6 restart uses staged pair");
  endtask

  task automatic test_reset_mid();
    int h, l, k;
    k = 0;
    start_burst();
    while (gate !== 1'b1 && k < 100) begin k++; @(negedge clk); end
    rstN = 1'b0;
    #1;
    check(int'(gate), 0, "R1 reset forces gate low");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    start_burst();
    run_len(1'b1, 100, h); check(h, 3, "R1 default high after reset");
    run_len(1'b0, 100, l); check(l, 5, "R1 default low after reset");
    pulse_meas(4'd5, 6'd0);
    run_len(1'b1, 100, h);
    run_len(1'b0, 100, l);
    run_len(1'b1, 100, h); check(h, 3, "R4 table entry reset to default");
  endtask

  initial begin
    rstN = 1'b0; aboveHi = 1'b0; belowLo = 1'b0;
    measCount = '0; measValid = 1'b0;
    tblWrEn = 1'b0; tblWrAddr = '0; tblWrHigh = '0; tblWrLow = '0;
    test_reset();
    test_default_and_write_only();
    test_select();
    test_clamp();
    test_stop();
    test_block();
    test_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(5.0 * 50000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule